// File: doc/BRIEF.md
# SPI Memory Command Front End

This block is the slave side of a serial byte-addressed memory. It watches chip select, serial clock, data in and a hold line, all sampled by the system clock. It assembles an 8-bit opcode after each chip-select fall and turns it into single-cycle requests on a parallel memory port. It also keeps the write-enable latch and the status byte, and it returns status or memory data on the serial output. Both idle clock polarities of the common rising-capture scheme work: polarity 0 with phase 0, and polarity 1 with phase 1.

Reads and writes carry a 16-bit address, sent most significant byte first. After the address, the block steps through consecutive bytes, wrapping from the top address to zero, until chip select rises. Both secure read and secure write take the same path as their plain forms; the checksum logic sits elsewhere. The serial-number commands use the same port with `mem_sn` raised and start at address zero. Non-volatile store, recall and the low-power entry leave the block only as one-cycle request pulses.

The serial pins are sampled by `clk`. Each serial clock phase must last at least four system clocks. The memory returns `mem_rdata` in the cycle after `mem_rd`.

Top module: `spi_mem_front`

## Requirements
- R1: Bits are captured on rising serial clock, most significant first. The first 8 bits after a chip-select fall form the opcode. The command set behaves identically with the clock idling low and with it idling high.
- R2: 0x06 sets the write-enable latch and 0x04 clears it. The status byte reads as follows: bit0 mirrors `nv_busy`, bit1 is the latch, bits 3:2 are the protect field, bit4 mirrors `sec_fail`, bit7 is the protect-enable bit, and bits 6:5 read 0.
- R3: Opcode 0x05 returns the status byte, most significant bit first. Output bits change after falling serial clock. `spi_miso_oe` is high only while output data is being returned and is low whenever `spi_cs_n` is high.
- R4: The write-type opcodes are 0x01, 0x02, 0x12 and 0xC2. While the latch is clear, each of them is refused: it raises no `mem_wr` and does not change the status byte.
- R5: The latch clears when chip select rises to end an accepted write-type command.
- R6: Opcodes 0x03 and 0x13 take a 16-bit address and then return the memory byte at that address. Later bytes come from successive addresses, and 0xFFFF is followed by 0x0000.
- R7: Opcodes 0x02 and 0x12 take a 16-bit address. After that, each completed 8-bit group raises one `mem_wr` at the current address, and the address then advances with wrap. A group with fewer than 8 bits writes nothing.
- R8: The protect field blocks `mem_wr` for array addresses as follows: 01 blocks 0xC000 to 0xFFFF, 10 blocks 0x8000 to 0xFFFF, and 11 blocks the whole array. The address still advances past a blocked byte.
- R9: Opcode 0x01 loads bit7 and bits 3:2 of its first data byte into the status byte. All other bits of the status byte are unaffected.
- R10: After an unknown opcode, the block ignores the rest of the select period and keeps `spi_miso_oe` low.
- R11: Hold is entered and left only while the serial clock is low. During hold, `spi_miso_oe` is low and clock edges are ignored. Chip select rising during hold aborts the command.
- R12: After reset, nothing is accepted until chip select has been seen high and then falls.
- R13: Opcode 0x08 gives a one-cycle `req_store`, 0x09 gives `req_recall` and 0xB9 gives `req_sleep`. Opcode 0xC2 writes and opcode 0xC3 reads with `mem_sn` high, starting at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock |
| spi_mosi | input | 1 | Serial data into the block |
| spi_hold_n | input | 1 | Pause request, active low |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for the serial data out pad |
| nv_busy | input | 1 | Busy flag shown in status bit0 |
| sec_fail | input | 1 | Secure-write failure flag shown in status bit4 |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Read request, one cycle |
| mem_rdata | input | 8 | Read data, valid the cycle after mem_rd |
| mem_wr | output | 1 | Write strobe, one cycle |
| mem_wdata | output | 8 | Write data |
| mem_sn | output | 1 | Access targets the serial-number space |
| req_store | output | 1 | Store request pulse |
| req_recall | output | 1 | Recall request pulse |
| req_sleep | output | 1 | Low-power entry request pulse |

## Verification
Two functions can meet in one system-clock cycle. The hold qualifier and the serial-clock edge detector both look at the same sampled clock level, so a clock edge and a hold change can land together. The bench enters hold with the clock low, partway through an opcode and partway through a status readout. It then toggles the clock and data lines while held, and releases hold. It judges the result by whether the completed opcode still takes effect and the returned status byte matches bit for bit. A second case raises chip select during hold and checks that the interrupted command is lost.

// File: rtl/spi_front_pkg.sv
package spi_front_pkg;

  typedef enum logic [2:0] {
    PH_OP, PH_ADDR, PH_DIN, PH_DOUT, PH_SIN, PH_SOUT, PH_PARK
  } phase_t;

  localparam logic [7:0] OPC_WEN_SET   = 8'h06;
  localparam logic [7:0] OPC_WEN_CLR   = 8'h04;
  localparam logic [7:0] OPC_STAT_RD   = 8'h05;
  localparam logic [7:0] OPC_STAT_WR   = 8'h01;
  localparam logic [7:0] OPC_ARR_RD    = 8'h03;
  localparam logic [7:0] OPC_ARR_RD_S  = 8'h13;
  localparam logic [7:0] OPC_ARR_WR    = 8'h02;
  localparam logic [7:0] OPC_ARR_WR_S  = 8'h12;
  localparam logic [7:0] OPC_NV_SAVE   = 8'h08;
  localparam logic [7:0] OPC_NV_LOAD   = 8'h09;
  localparam logic [7:0] OPC_SN_WR     = 8'hC2;
  localparam logic [7:0] OPC_SN_RD     = 8'hC3;
  localparam logic [7:0] OPC_SLEEP     = 8'hB9;

  // Protect field against the two top address bits.
  function automatic logic blk_locked(input logic [1:0] bp, input logic [1:0] top2);
    case (bp)
      2'b00:   return 1'b0;
      2'b01:   return top2 == 2'b11;
      2'b10:   return top2[1];
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] status_pack(input logic wpen, input logic swm,
                                             input logic [1:0] bp, input logic wen,
                                             input logic busy);
    return {wpen, 2'b00, swm, bp, wen, busy};
  endfunction

endpackage

// File: rtl/spi_link_cond.sv
module spi_link_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic hold_n,
  output logic sess,
  output logic hold_act,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_rise
);
  logic cs_q, sck_q;
  logic cs_fall;

  // cs_q resets low so a select already low at reset is not a fall.
  assign cs_fall  = cs_q & ~cs_n;
  assign cs_rise  = cs_n & ~cs_q;
  assign sck_rise = sess & ~cs_n & ~hold_act & sck & ~sck_q;
  assign sck_fall = sess & ~cs_n & ~hold_act & ~sck & sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q     <= 1'b0;
      sck_q    <= 1'b0;
      sess     <= 1'b0;
      hold_act <= 1'b0;
    end else begin
      cs_q  <= cs_n;
      sck_q <= sck;
      if (cs_n)         sess <= 1'b0;
      else if (cs_fall) sess <= 1'b1;
      if (cs_n || !sess) hold_act <= 1'b0;
      else if (!sck)     hold_act <= ~hold_n;
    end
  end
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_front_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sess,
  input  logic          hold_act,
  input  logic          cs_rise,
  input  logic          sck_rise,
  input  logic          sck_fall,
  input  logic          mosi,
  input  logic          busy_in,
  input  logic          swm_in,
  input  logic [7:0]    mem_rdata,
  output logic          miso_bit,
  output logic          out_en,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [7:0]    mem_wdata,
  output logic          mem_sn,
  output logic          req_store,
  output logic          req_recall,
  output logic          req_sleep,
  output logic          wen
);
  localparam int ABYTES = AW / 8;
  localparam int ABW    = (ABYTES > 1) ? $clog2(ABYTES) : 1;
  localparam logic [ABW-1:0] ALAST = ABW'(ABYTES - 1);

  phase_t          phase;
  logic [2:0]      bitcnt;
  logic [6:0]      rx;
  logic [ABW-1:0]  abc;
  logic            wpen, wcmd, is_rd, rd_q, step;
  logic [1:0]      bp;
  logic [7:0]      tx, rbuf, status;
  logic [7:0]      byte_in;

  assign byte_in  = {rx, mosi};
  assign status   = status_pack(wpen, swm_in, bp, wen, busy_in);
  assign miso_bit = tx[7];
  assign out_en   = sess & ~hold_act & (phase == PH_DOUT || phase == PH_SOUT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_OP;  bitcnt <= '0;  rx <= '0;  abc <= '0;
      mem_addr <= '0;  wen <= 1'b0;  wpen <= 1'b0;  bp <= '0;
      wcmd <= 1'b0;  is_rd <= 1'b0;  tx <= '0;  rbuf <= '0;
      rd_q <= 1'b0;  step <= 1'b0;  mem_rd <= 1'b0;  mem_wr <= 1'b0;
      mem_wdata <= '0;  mem_sn <= 1'b0;
      req_store <= 1'b0;  req_recall <= 1'b0;  req_sleep <= 1'b0;
    end else begin
      mem_rd <= 1'b0;  mem_wr <= 1'b0;  step <= 1'b0;
      req_store <= 1'b0;  req_recall <= 1'b0;  req_sleep <= 1'b0;
      rd_q <= mem_rd;
      if (rd_q) rbuf <= mem_rdata;
      if (step) begin
        mem_addr <= mem_addr + 1'b1;
        if (is_rd) mem_rd <= 1'b1;          // prefetch the next byte
      end
      if (cs_rise && wcmd) wen <= 1'b0;
      if (!sess) begin
        phase <= PH_OP;  bitcnt <= '0;  abc <= '0;  wcmd <= 1'b0;  mem_sn <= 1'b0;
      end else begin
        if (sck_rise) begin
          rx     <= byte_in[6:0];
          bitcnt <= bitcnt + 1'b1;
          if (bitcnt == 3'd7) begin
            case (phase)
              PH_OP: begin
                phase <= PH_PARK;
                case (byte_in)
                  OPC_WEN_SET: wen <= 1'b1;
                  OPC_WEN_CLR: wen <= 1'b0;
                  OPC_STAT_RD: phase <= PH_SOUT;
                  OPC_STAT_WR: if (wen) begin phase <= PH_SIN; wcmd <= 1'b1; end
                  OPC_ARR_RD, OPC_ARR_RD_S: begin
                    is_rd <= 1'b1;  abc <= '0;  phase <= PH_ADDR;
                  end
                  OPC_ARR_WR, OPC_ARR_WR_S: if (wen) begin
                    is_rd <= 1'b0;  abc <= '0;  phase <= PH_ADDR;  wcmd <= 1'b1;
                  end
                  OPC_SN_WR: if (wen) begin
                    is_rd <= 1'b0;  mem_sn <= 1'b1;  mem_addr <= '0;
                    phase <= PH_DIN;  wcmd <= 1'b1;
                  end
                  OPC_SN_RD: begin
                    is_rd <= 1'b1;  mem_sn <= 1'b1;  mem_addr <= '0;
                    mem_rd <= 1'b1;  phase <= PH_DOUT;
                  end
                  OPC_NV_SAVE: req_store  <= 1'b1;
                  OPC_NV_LOAD: req_recall <= 1'b1;
                  OPC_SLEEP:   req_sleep  <= 1'b1;
                  default: ;                       // unknown: parked until reselect
                endcase
              end
              PH_ADDR: begin
                mem_addr <= AW'({mem_addr, byte_in});
                if (abc == ALAST) begin
                  phase  <= is_rd ? PH_DOUT : PH_DIN;
                  mem_rd <= is_rd;
                end else begin
                  abc <= abc + 1'b1;
                end
              end
              PH_DIN: begin
                mem_wdata <= byte_in;
                mem_wr    <= mem_sn || !blk_locked(bp, mem_addr[AW-1 -: 2]);
                step      <= 1'b1;
              end
              PH_SIN: begin
                wpen  <= byte_in[7];
                bp    <= byte_in[3:2];
                phase <= PH_PARK;
              end
              default: ;
            endcase
          end
        end
        if (sck_fall) begin
          if (bitcnt == 3'd0 && phase == PH_DOUT) begin
            tx   <= rbuf;
            step <= 1'b1;
          end else if (bitcnt == 3'd0 && phase == PH_SOUT) begin
            tx <= status;
          end else begin
            tx <= {tx[6:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_mem_front.sv
module spi_mem_front #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_cs_n,
  input  logic          spi_sck,
  input  logic          spi_mosi,
  input  logic          spi_hold_n,
  output logic          spi_miso,
  output logic          spi_miso_oe,
  input  logic          nv_busy,
  input  logic          sec_fail,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  input  logic [7:0]    mem_rdata,
  output logic          mem_wr,
  output logic [7:0]    mem_wdata,
  output logic          mem_sn,
  output logic          req_store,
  output logic          req_recall,
  output logic          req_sleep
);
  logic sess, hold_act, sck_rise, sck_fall, cs_rise;
  logic miso_bit, out_en, wen;

  spi_link_cond u_link (
    .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sck(spi_sck), .hold_n(spi_hold_n),
    .sess(sess), .hold_act(hold_act), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .cs_rise(cs_rise)
  );

  spi_cmd_engine #(.AW(AW)) u_eng (
    .clk(clk), .rst_n(rst_n), .sess(sess), .hold_act(hold_act), .cs_rise(cs_rise),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi(spi_mosi),
    .busy_in(nv_busy), .swm_in(sec_fail), .mem_rdata(mem_rdata),
    .miso_bit(miso_bit), .out_en(out_en), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_sn(mem_sn),
    .req_store(req_store), .req_recall(req_recall), .req_sleep(req_sleep), .wen(wen)
  );

  assign spi_miso_oe = out_en & ~spi_cs_n;
  assign spi_miso    = miso_bit & spi_miso_oe;
endmodule

// File: rtl/spi_mem_front_chk.sv
module spi_mem_front_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          spi_cs_n,
  input logic          spi_miso_oe,
  input logic          hold_act,
  input logic          sck_rise,
  input logic          wen,
  input logic          mem_wr,
  input logic [AW-1:0] mem_addr,
  input logic          req_store,
  input logic          req_recall,
  input logic          req_sleep
);
  a_r3_deselect_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_miso_oe);

  a_r11_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    hold_act |-> (!spi_miso_oe && !sck_rise));

  a_r4_write_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> wen);

  a_r7_addr_advance: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> (mem_addr == AW'($past(mem_addr) + 1'b1)));

  a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> !mem_wr);

  a_r13_one_request: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_store, req_recall, req_sleep}));

  a_r13_store_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    req_store |=> !req_store);
endmodule

bind spi_mem_front spi_mem_front_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_miso_oe(spi_miso_oe),
  .hold_act(hold_act), .sck_rise(sck_rise), .wen(wen), .mem_wr(mem_wr),
  .mem_addr(mem_addr), .req_store(req_store), .req_recall(req_recall),
  .req_sleep(req_sleep)
);

// File: tb/spi_mem_front_bench.sv
module spi_mem_front_bench;
  localparam int H = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic spi_cs_n = 1'b0, spi_sck = 1'b0, spi_mosi = 1'b0, spi_hold_n = 1'b1;
  logic nv_busy = 1'b0, sec_fail = 1'b0;
  logic spi_miso, spi_miso_oe, mem_rd, mem_wr, mem_sn;
  logic req_store, req_recall, req_sleep;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata = 8'h00, mem_wdata;

  int checks = 0, errors = 0, cycles = 0;
  int wr_n = 0, n_store = 0, n_recall = 0, n_sleep = 0;
  logic [15:0] log_a [0:15];
  logic [7:0]  log_d [0:15];
  logic        log_s [0:15];
  logic [7:0]  rb [0:3];
  logic        oe_seen = 1'b0;

  always #5 clk = ~clk;

  spi_mem_front u_spi_mem_front (.*);

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] + 8'(3 * a[15:8]) + 8'h11;
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (mem_rd) mem_rdata <= pat(mem_addr);
    if (mem_wr) begin
      log_a[wr_n[3:0]] <= mem_addr;
      log_d[wr_n[3:0]] <= mem_wdata;
      log_s[wr_n[3:0]] <= mem_sn;
      wr_n <= wr_n + 1;
    end
    if (req_store)  n_store  <= n_store + 1;
    if (req_recall) n_recall <= n_recall + 1;
    if (req_sleep)  n_sleep  <= n_sleep + 1;
  end
  always @(negedge clk) if (spi_miso_oe) oe_seen <= 1'b1;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbit(input logic b, output logic r);
    @(negedge clk); spi_sck <= 1'b0; spi_mosi <= b;
    waitn(H); r = spi_miso; spi_sck <= 1'b1;
    waitn(H);
  endtask

  task automatic sbits(input logic [7:0] t, input int n, output logic [7:0] r);
    r = '0;
    for (int i = 7; i > 7 - n; i--) begin
      logic b;
      sbit(t[i], b);
      r[i] = b;
    end
  endtask

  task automatic xb(input logic [7:0] t, output logic [7:0] r);
    sbits(t, 8, r);
  endtask

  task automatic sel(input logic m3);
    @(negedge clk); spi_cs_n <= 1'b1; spi_sck <= m3;
    waitn(4); spi_cs_n <= 1'b0; waitn(H);
  endtask

  task automatic desel(input logic m3);
    @(negedge clk);
    if (!m3) begin spi_sck <= 1'b0; waitn(H); end
    spi_cs_n <= 1'b1; waitn(H);
  endtask

  task automatic op1(input logic [7:0] op, input logic m3);
    logic [7:0] r;
    sel(m3); xb(op, r); desel(m3);
  endtask

  task automatic rdsr(input logic m3, output logic [7:0] s);
    logic [7:0] r;
    sel(m3); xb(8'h05, r); xb(8'h00, s); desel(m3);
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] r;
    op1(8'h06, 1'b0);
    sel(1'b0); xb(8'h01, r); xb(v, r); desel(1'b0);
  endtask

  task automatic xfer(input logic [7:0] op, input logic m3, input logic [15:0] a, input int n);
    logic [7:0] r;
    sel(m3); xb(op, r); xb(a[15:8], r); xb(a[7:0], r);
    for (int i = 0; i < n; i++) begin xb(8'hA0 + 8'(i), r); rb[i] = r; end
    desel(m3);
  endtask

  task automatic t_arm;
    logic [7:0] s, r;
    chk("R3 reset oe", spi_miso_oe, 0);
    xb(8'h06, r); desel(1'b0);          // select was low through reset
    rdsr(1'b0, s);
    chk("R12 no command before fall", s, 8'h00);
  endtask

  task automatic t_status;
    logic [7:0] s;
    op1(8'h06, 1'b0); rdsr(1'b0, s); chk("R2 latch set mode0", s, 8'h02);
    rdsr(1'b1, s);                       chk("R1 status mode3", s, 8'h02);
    nv_busy = 1'b1; sec_fail = 1'b1;
    rdsr(1'b1, s);                       chk("R2 busy/fail bits", s, 8'h13);
    nv_busy = 1'b0; sec_fail = 1'b0;
    op1(8'h04, 1'b1); rdsr(1'b0, s);     chk("R2 latch clear mode3", s, 8'h00);
  endtask

  task automatic t_refuse;
    logic [7:0] s, r;
    int b = wr_n;
    xfer(8'h02, 1'b0, 16'h0010, 1);
    sel(1'b0); xb(8'h01, r); xb(8'h8C, r); desel(1'b0);
    chk("R4 write refused", wr_n - b, 0);
    rdsr(1'b0, s); chk("R4 status unchanged", s, 8'h00);
  endtask

  task automatic t_write;
    logic [7:0] s, r;
    int b = wr_n;
    op1(8'h06, 1'b0);
    sel(1'b0); xb(8'h02, r); xb(8'h12, r); xb(8'h34, r);
    xb(8'hA1, r); xb(8'hB2, r); xb(8'hC3, r); sbits(8'hFF, 4, r); desel(1'b0);
    chk("R7 three whole bytes only", wr_n - b, 3);
    chk("R7 addr0", log_a[b[3:0]], 16'h1234);
    chk("R7 data2", {log_a[4'(b + 2)], log_d[4'(b + 2)]}, {16'h1236, 8'hC3});
    rdsr(1'b0, s); chk("R5 latch cleared after write", s, 8'h00);
    b = wr_n;
    op1(8'h06, 1'b1); xfer(8'h12, 1'b1, 16'hFFFF, 2);
    chk("R7 wrap", {log_a[b[3:0]], log_a[4'(b + 1)]}, {16'hFFFF, 16'h0000});
  endtask

  task automatic t_read;
    xfer(8'h03, 1'b1, 16'h00FF, 2);
    chk("R6 read first", rb[0], pat(16'h00FF));
    chk("R6 read next", rb[1], pat(16'h0100));
    xfer(8'h13, 1'b0, 16'hFFFF, 2);
    chk("R6 read wrap", {rb[0], rb[1]}, {pat(16'hFFFF), pat(16'h0000)});
  endtask

  task automatic t_protect;
    logic [7:0] s;
    int b;
    wrsr(8'h04); rdsr(1'b0, s); chk("R9 protect field 01", s, 8'h04);
    b = wr_n; op1(8'h06, 1'b0); xfer(8'h02, 1'b0, 16'hBFFF, 2);
    chk("R8 quarter lock count", wr_n - b, 1);
    chk("R8 quarter lock addr", log_a[b[3:0]], 16'hBFFF);
    wrsr(8'h08);
    b = wr_n; op1(8'h06, 1'b0); xfer(8'h02, 1'b0, 16'h7FFF, 2);
    chk("R8 half lock", {8'(wr_n - b), log_a[b[3:0]]}, {8'd1, 16'h7FFF});
    wrsr(8'h8C); rdsr(1'b1, s); chk("R9 enable and field", s, 8'h8C);
    b = wr_n; op1(8'h06, 1'b0); xfer(8'h02, 1'b0, 16'h0000, 1);
    chk("R8 full lock", wr_n - b, 0);
    wrsr(8'h60); rdsr(1'b0, s); chk("R9 reserved bits ignored", s, 8'h00);
  endtask

  task automatic t_invalid;
    logic [7:0] s, r;
    oe_seen = 1'b0;
    sel(1'b0); xb(8'h55, r); xb(8'h06, r); xb(8'h05, r); xb(8'h00, r); desel(1'b0);
    chk("R10 output stays off", oe_seen, 0);
    rdsr(1'b0, s); chk("R10 later bytes ignored", s, 8'h00);
  endtask

  task automatic t_hold;
    logic [7:0] s, r, hi, lo;
    sel(1'b0); sbits(8'h00, 4, r);
    @(negedge clk); spi_sck <= 1'b0; waitn(H);
    spi_hold_n <= 1'b0; waitn(H);
    for (int i = 0; i < 2; i++) begin
      spi_mosi <= 1'b1; spi_sck <= 1'b1; waitn(H); spi_sck <= 1'b0; waitn(H);
    end
    spi_hold_n <= 1'b1; waitn(H);
    sbits(8'h60, 4, r); desel(1'b0);
    rdsr(1'b0, s); chk("R11 edges ignored in hold", s, 8'h02);
    sel(1'b0); xb(8'h05, r); sbits(8'h00, 3, hi);
    @(negedge clk); spi_sck <= 1'b0; waitn(H);
    spi_hold_n <= 1'b0; waitn(H);
    chk("R11 output off in hold", spi_miso_oe, 0);
    spi_sck <= 1'b1; waitn(H); spi_sck <= 1'b0; waitn(H);
    spi_hold_n <= 1'b1; waitn(H);
    for (int i = 4; i >= 0; i--) begin logic bb; sbit(1'b0, bb); lo[i] = bb; end
    desel(1'b0);
    chk("R11 status across hold", {hi[7:5], lo[4:0]}, 8'h02);
    op1(8'h04, 1'b0);
    sel(1'b0); sbits(8'h00, 4, r);
    @(negedge clk); spi_sck <= 1'b0; waitn(H);
    spi_hold_n <= 1'b0; waitn(H); spi_cs_n <= 1'b1; waitn(H); spi_hold_n <= 1'b1;
    sel(1'b0); sbits(8'h60, 4, r); desel(1'b0);
    rdsr(1'b0, s); chk("R11 select rise aborts", s, 8'h00);
  endtask

  task automatic t_requests;
    logic [7:0] s, r;
    int b;
    op1(8'h08, 1'b0); op1(8'h09, 1'b1); op1(8'hB9, 1'b0);
    chk("R13 pulses", {8'(n_store), 8'(n_recall), 8'(n_sleep)}, 24'h010101);
    b = wr_n;
    op1(8'h06, 1'b0);
    sel(1'b0); xb(8'hC2, r); xb(8'h77, r); desel(1'b0);
    chk("R13 serial write", {log_s[b[3:0]], log_a[b[3:0]], log_d[b[3:0]]}, {1'b1, 16'h0000, 8'h77});
    rdsr(1'b0, s); chk("R5 latch cleared after serial write", s, 8'h00);
    sel(1'b1); xb(8'hC3, r); xb(8'h00, r); desel(1'b1);
    chk("R13 serial read", r, pat(16'h0000));
  endtask

  initial begin
    waitn(5); rst_n = 1'b1; waitn(4);
    t_arm();
    t_status();
    t_refuse();
    t_write();
    t_read();
    t_protect();
    t_invalid();
    t_hold();
    t_requests();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule